// File: doc/BRIEF.md
# Divide-by-three clock and ready generator

This block runs entirely from a fast oscillator clock. From it, the block derives a processor clock at one third of the oscillator rate, high for one oscillator period and low for two. It also derives a peripheral clock at half the processor rate, which has an even duty cycle and changes only on processor-clock rising edges. The oscillator itself is passed straight through as a third clock output.

An asynchronous, active-high reset request goes through a two-flop synchronizer. While the request is active, both dividers are held at a fixed phase. The reset output releases only on a falling edge of the processor clock, so the first processor-clock pulse comes at a fixed number of oscillator edges after release.

Two ready requests can each be enabled by their own active-low enable. The enabled requests are ORed, pass through a two-stage synchronizer, and then drive a READY output. READY is only updated on a processor-clock falling edge. A low READY tells the processor to insert wait states.

Top module: `clkgen_top`

## Requirements
- R1: The processor clock `cpu_clk_o` repeats with a period of exactly DIV_RATIO (default 3) oscillator periods.
- R2: Within each period, `cpu_clk_o` is high for HIGH_CYCLES (default 1) oscillator periods and low for the remaining two.
- R3: The peripheral clock `per_clk_o` is high for three and low for three oscillator periods. It toggles only on the edges where `cpu_clk_o` rises.
- R4: `osc_o` always equals `osc_i`.
- R5: While `rst_req_i` is high, `rst_o` is high and both `cpu_clk_o` and `per_clk_o` are held low. Once the request is active, this state is reached by the first oscillator rising edge.
- R6: Count the oscillator rising edges after `rst_req_i` falls. `cpu_clk_o` and `per_clk_o` first go high at the 3rd edge. `rst_o` falls at the 4th edge, which is the edge where `cpu_clk_o` falls.
- R7: The qualified request is (`rdy_a_i` AND NOT `rdy_a_en_n_i`) OR (`rdy_b_i` AND NOT `rdy_b_en_n_i`). An enable held at 1 makes its request have no effect on `ready_o`.
- R8: After the qualified request changes, `ready_o` takes the new value on the first oscillator edge, no earlier than the 3rd edge, at which `cpu_clk_o` falls. At no other time does `ready_o` change.
- R9: `ready_o` is 0 during reset, so wait states are requested.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| osc_i | input | 1 | Oscillator clock; all logic is clocked by it |
| rst_req_i | input | 1 | Asynchronous active-high reset request |
| rdy_a_i | input | 1 | Ready request, source A |
| rdy_a_en_n_i | input | 1 | Active-low enable for source A |
| rdy_b_i | input | 1 | Ready request, source B |
| rdy_b_en_n_i | input | 1 | Active-low enable for source B |
| osc_o | output | 1 | Oscillator pass-through |
| cpu_clk_o | output | 1 | Processor clock, one third of the oscillator rate, one-third duty |
| per_clk_o | output | 1 | Peripheral clock, half the processor rate, 50% duty |
| rst_o | output | 1 | Synchronized active-high reset, released on a processor-clock falling edge |
| ready_o | output | 1 | Synchronized READY, updated on processor-clock falling edges |

## Verification
The hardest case to reach is a ready change that lands in each of the three processor-clock phases. In that case the update delay varies by whole oscillator periods, depending on where the falling edge falls relative to the synchronizer output. The bench repeats each ready change after a skew of zero, one and two extra oscillator edges, so every phase is covered. At each edge it predicts the update edge from the observed falling edges of `cpu_clk_o`. It also releases reset on a known edge and counts edges to the first clock pulse and to the release of `rst_o`.

// File: rtl/clkgen_pkg.sv
package clkgen_pkg;
   // width of a counter that holds values 0 .. n-1 (at least one bit)
   function automatic int unsigned cnt_width(input int unsigned n);
      int unsigned w;
      w = 1;
      while ((1 << w) < n) w++;
      return w;
   endfunction
endpackage

// File: rtl/clkgen_sync_chain.sv
module clkgen_sync_chain #(
   parameter int unsigned STAGES    = 2,
   parameter bit          RESET_VAL = 1'b0
) (
   input  logic clk_i,
   input  logic arst_i,
   input  logic d_i,
   output logic q_o
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("clkgen_sync_chain: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] chain_q;

   generate
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         always_ff @(posedge clk_i or posedge arst_i) begin
            if (arst_i) begin
               chain_q[s] <= RESET_VAL;
            end else begin
               if (s == 0) chain_q[s] <= d_i;
               else        chain_q[s] <= chain_q[(s == 0) ? 0 : s-1];
            end
         end
      end
   endgenerate

   assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/clkgen_phase_div.sv
module clkgen_phase_div
   import clkgen_pkg::*;
#(
   parameter int unsigned DIV_RATIO   = 3,
   parameter int unsigned HIGH_CYCLES = 1
) (
   input  logic clk_i,
   input  logic hold_i,
   output logic cpu_clk_o,
   output logic per_clk_o,
   output logic cpu_fall_o
);
   localparam int unsigned CW = cnt_width(DIV_RATIO);
   localparam logic [CW-1:0] LAST = CW'(DIV_RATIO - 1);
   localparam logic [CW-1:0] HIGH = CW'(HIGH_CYCLES);

   generate
      if (DIV_RATIO < 2) begin : g_bad_ratio
         $error("clkgen_phase_div: DIV_RATIO must be at least 2");
      end
      if (HIGH_CYCLES < 1 || HIGH_CYCLES >= DIV_RATIO) begin : g_bad_high
         $error("clkgen_phase_div: HIGH_CYCLES must lie in 1 .. DIV_RATIO-1");
      end
   endgenerate

   logic [CW-1:0] phase_q, phase_nx;
   logic          cpu_q, per_q;

   always_comb begin
      if (hold_i)               phase_nx = LAST;
      else if (phase_q == LAST) phase_nx = '0;
      else                      phase_nx = phase_q + 1'b1;
   end

   always_ff @(posedge clk_i) begin
      phase_q <= phase_nx;
      cpu_q   <= !hold_i && (phase_nx < HIGH);
      if (hold_i)              per_q <= 1'b0;
      else if (phase_nx == '0) per_q <= ~per_q;
   end

   assign cpu_clk_o  = cpu_q;
   assign per_clk_o  = per_q;
   assign cpu_fall_o = !hold_i && (phase_nx == HIGH);

   // checker: length of the current high run of the processor clock
   logic [CW-1:0] hi_len_q;
   always_ff @(posedge clk_i) begin
      if (hold_i)     hi_len_q <= '0;
      else if (cpu_q) hi_len_q <= hi_len_q + 1'b1;
      else            hi_len_q <= '0;
   end

   AST_CPU_HIGH_WIDTH: assert property (@(posedge clk_i) disable iff (hold_i)
      $fell(cpu_q) |-> (hi_len_q == HIGH)); // R2
   AST_PER_ON_CPU_RISE: assert property (@(posedge clk_i) disable iff (hold_i)
      !$stable(per_q) |-> $rose(cpu_q)); // R3
endmodule

// File: rtl/clkgen_ready_gen.sv
module clkgen_ready_gen #(
   parameter int unsigned NUM_SRC = 2,
   parameter int unsigned STAGES  = 2
) (
   input  logic               clk_i,
   input  logic               rst_i,
   input  logic [NUM_SRC-1:0] req_i,
   input  logic [NUM_SRC-1:0] en_n_i,
   input  logic               upd_i,
   output logic               ready_o
);
   generate
      if (NUM_SRC < 1) begin : g_bad_src
         $error("clkgen_ready_gen: NUM_SRC must be at least 1");
      end
   endgenerate

   logic [NUM_SRC-1:0] qual;
   logic               any_req, synced, ready_q;

   generate
      for (genvar i = 0; i < NUM_SRC; i++) begin : g_qual
         assign qual[i] = req_i[i] & ~en_n_i[i];
      end
   endgenerate

   assign any_req = |qual;

   clkgen_sync_chain #(.STAGES(STAGES), .RESET_VAL(1'b0)) u_rdy_sync (
      .clk_i (clk_i),
      .arst_i(rst_i),
      .d_i   (any_req),
      .q_o   (synced)
   );

   always_ff @(posedge clk_i or posedge rst_i) begin
      if (rst_i)      ready_q <= 1'b0;
      else if (upd_i) ready_q <= synced;
   end

   assign ready_o = ready_q;

   AST_READY_ON_FALL: assert property (@(posedge clk_i) disable iff (rst_i)
      !$stable(ready_q) |-> $past(upd_i)); // R8
endmodule

// File: rtl/clkgen_top.sv
module clkgen_top #(
   parameter int unsigned DIV_RATIO   = 3,
   parameter int unsigned HIGH_CYCLES = 1,
   parameter int unsigned RST_STAGES  = 2,
   parameter int unsigned RDY_STAGES  = 2
) (
   input  logic osc_i,
   input  logic rst_req_i,
   input  logic rdy_a_i,
   input  logic rdy_a_en_n_i,
   input  logic rdy_b_i,
   input  logic rdy_b_en_n_i,
   output logic osc_o,
   output logic cpu_clk_o,
   output logic per_clk_o,
   output logic rst_o,
   output logic ready_o
);
   logic rst_int, cpu_fall, rst_q;

   assign osc_o = osc_i;

   clkgen_sync_chain #(.STAGES(RST_STAGES), .RESET_VAL(1'b1)) u_rst_sync (
      .clk_i (osc_i),
      .arst_i(rst_req_i),
      .d_i   (1'b0),
      .q_o   (rst_int)
   );

   clkgen_phase_div #(.DIV_RATIO(DIV_RATIO), .HIGH_CYCLES(HIGH_CYCLES)) u_div (
      .clk_i     (osc_i),
      .hold_i    (rst_int),
      .cpu_clk_o (cpu_clk_o),
      .per_clk_o (per_clk_o),
      .cpu_fall_o(cpu_fall)
   );

   // reset output: set while synchronized reset is active, cleared on a falling edge
   always_ff @(posedge osc_i) begin
      if (rst_int)       rst_q <= 1'b1;
      else if (cpu_fall) rst_q <= 1'b0;
   end
   assign rst_o = rst_q;

   clkgen_ready_gen #(.NUM_SRC(2), .STAGES(RDY_STAGES)) u_ready (
      .clk_i  (osc_i),
      .rst_i  (rst_int),
      .req_i  ({rdy_b_i, rdy_a_i}),
      .en_n_i ({rdy_b_en_n_i, rdy_a_en_n_i}),
      .upd_i  (cpu_fall),
      .ready_o(ready_o)
   );

   AST_RST_RELEASE_ON_FALL: assert property (@(posedge osc_i) disable iff (rst_req_i)
      $fell(rst_o) |-> $fell(cpu_clk_o)); // R6
   AST_READY_LOW_IN_RESET: assert property (@(posedge osc_i) disable iff (!rst_req_i)
      rst_req_i |=> !ready_o); // R9
endmodule

// File: tb/clkgen_top_tb_top.sv
`timescale 1ns/1ps
module clkgen_top_tb_top;
   logic osc = 1'b0;
   logic rst_req = 1'b0;
   logic rdy_a = 1'b0, rdy_a_en_n = 1'b1, rdy_b = 1'b0, rdy_b_en_n = 1'b1;
   logic osc_o, cpu_clk, per_clk, rst_o, ready;
   int n_cmp = 0, n_mis = 0;

   always #2.5 osc = ~osc;

   clkgen_top dut_i (
      .osc_i(osc), .rst_req_i(rst_req),
      .rdy_a_i(rdy_a), .rdy_a_en_n_i(rdy_a_en_n),
      .rdy_b_i(rdy_b), .rdy_b_en_n_i(rdy_b_en_n),
      .osc_o(osc_o), .cpu_clk_o(cpu_clk), .per_clk_o(per_clk),
      .rst_o(rst_o), .ready_o(ready)
   );

   task automatic check(input string req, input string what, input logic act, input logic exp);
      n_cmp++;
      if (act !== exp) begin
         n_mis++;
         $display("FAIL %s %s: actual=%b expected=%b at %0t", req, what, act, exp, $time);
      end
   endtask

   task automatic edge_after();
      @(posedge osc); #1;
   endtask

   task automatic t_reset_state();
      @(negedge osc); rst_req = 1'b1;
      edge_after();
      edge_after();
      check("R5", "rst_o in reset", rst_o, 1'b1);
      check("R5", "cpu_clk held low", cpu_clk, 1'b0);
      check("R5", "per_clk held low", per_clk, 1'b0);
      check("R9", "ready low in reset", ready, 1'b0);
      check("R4", "osc_o high phase", osc_o, osc);
      @(negedge osc); #1;
      check("R4", "osc_o low phase", osc_o, osc);
   endtask

   task automatic t_release();
      @(negedge osc); rst_req = 1'b0;
      edge_after();
      check("R6", "edge1 cpu", cpu_clk, 1'b0);
      check("R6", "edge1 rst_o", rst_o, 1'b1);
      edge_after();
      check("R6", "edge2 cpu", cpu_clk, 1'b0);
      check("R6", "edge2 rst_o", rst_o, 1'b1);
      edge_after();
      check("R6", "edge3 cpu rises", cpu_clk, 1'b1);
      check("R6", "edge3 per rises", per_clk, 1'b1);
      check("R6", "edge3 rst_o", rst_o, 1'b1);
      edge_after();
      check("R6", "edge4 cpu falls", cpu_clk, 1'b0);
      check("R6", "edge4 rst_o falls", rst_o, 1'b0);
   endtask

   task automatic t_clock_shape();
      logic prev, p0;
      int cpu_err = 0, per_err = 0;
      prev = cpu_clk;
      forever begin
         edge_after();
         if (cpu_clk && !prev) break;
         prev = cpu_clk;
      end
      p0 = per_clk;
      for (int k = 0; k < 24; k++) begin
         if (k > 0) edge_after();
         if (cpu_clk !== ((k % 3) == 0)) cpu_err++;
         if (per_clk !== (p0 ^ (((k / 3) % 2) == 1))) per_err++;
      end
      check("R1", "cpu period 3 over 24 edges", cpu_err == 0, 1'b1);
      check("R2", "cpu high 1 low 2", cpu_err == 0, 1'b1);
      check("R3", "per high 3 low 3 aligned to cpu rise", per_err == 0, 1'b1);
   endtask

   // apply ready inputs after a skew, then follow edges to the predicted update
   task automatic t_ready(input string req, input int skew, input logic a, input logic aen_n,
                          input logic b, input logic ben_n);
      logic oldv, newv, prev;
      bit done;
      for (int s = 0; s < skew; s++) @(posedge osc);
      @(negedge osc);
      oldv = ready;
      newv = (a & ~aen_n) | (b & ~ben_n);
      rdy_a = a; rdy_a_en_n = aen_n; rdy_b = b; rdy_b_en_n = ben_n;
      prev = cpu_clk;
      done = 1'b0;
      for (int k = 1; k <= 8; k++) begin
         edge_after();
         if (!done) begin
            if (k >= 3 && prev && !cpu_clk) begin
               check(req, "ready at first fall after sync", ready, newv);
               done = 1'b1;
            end else begin
               check("R8", "ready held before update edge", ready, oldv);
            end
         end
         prev = cpu_clk;
      end
      check(req, "update edge reached", done, 1'b1);
   endtask

   task automatic t_reset_midrun();
      @(negedge osc); rst_req = 1'b1;
      edge_after();
      check("R5", "rst_o asserts mid-run", rst_o, 1'b1);
      check("R5", "cpu low after reset", cpu_clk, 1'b0);
      check("R5", "per low after reset", per_clk, 1'b0);
      check("R9", "ready cleared by reset", ready, 1'b0);
   endtask

   initial begin
      #(200000 * 5);
      n_mis++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_mis);
      $finish;
   end

   initial begin
      #1;
      t_reset_state();
      t_release();
      t_clock_shape();
      for (int sk = 0; sk < 3; sk++) begin
         t_ready("R7", sk, 1'b1, 1'b0, 1'b0, 1'b1);  // source A enabled -> 1
         t_ready("R7", sk, 1'b1, 1'b1, 1'b0, 1'b1);  // A disabled: request ignored -> 0
         t_ready("R7", sk, 1'b0, 1'b1, 1'b1, 1'b0);  // source B enabled -> 1
         t_ready("R8", sk, 1'b1, 1'b1, 1'b1, 1'b1);  // both disabled -> 0
      end
      t_reset_midrun();
      t_release();
      t_clock_shape();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_mis);
      $finish;
   end
endmodule